// File: doc/BRIEF.md
# Task Submission and Completion Queue Pair

This block is the central synchronization point between one controlling master and a set of worker engines. The master pushes 64-bit task entries into a submission queue. Workers poll that queue to claim work one entry at a time, and each poll is answered at once, with or without a task. When a worker finishes a task, it pushes a completion record into a second, independent queue. The master drains the completion queue to collect the results.

The block keeps a count of the tasks that have been submitted but not yet reported complete. The master marks the end of a submission phase with a finish request. A barrier flag rises once that finish mark is set and the count has reached zero, so the master knows that the phase can close.

Every response is delayed by a configurable number of cycles. This lets a system study how sensitive it is to slow access to this shared resource.

Top module: `task_sync_queue`

## Requirements
- R1: After reset both queues are empty, `outstanding` is 0, `barrier_done` is 0, and no response or grant is driven.
- R2: A task entry is 64 bits: bits 63:48 hold the task identifier and bits 47:0 hold the parameter pointer. The master op SUBMIT (code 0) stores the entry. Worker polls (op 0) return the stored entries unchanged, in first-in first-out order, with response code OK (0).
- R3: A poll on an empty submission queue returns code EMPTY (1) with zero data in a single transaction, and it changes no queue state.
- R4: A SUBMIT is refused with code RETRY (2) when the submission queue is full or `outstanding` equals MAX_OUTSTANDING. A completion push is refused with RETRY when the completion queue is full. A refused push overwrites no entry and does not change the count.
- R5: Each accepted request produces exactly one response, valid exactly RSP_LAT cycles after the clock edge that accepted it, and not before.
- R6: At most one worker request is granted per cycle. The grant goes to the first requesting worker at or after the index that follows the last granted worker, wrapping around; after reset that index is worker 0.
- R7: A response is delivered to the requesting worker only, and each popped submission entry is handed to exactly one worker.
- R8: A worker op COMPLETE (op 1) pushes its 64-bit record into the completion queue. The master op DRAIN (code 1) returns completion records in order with OK, or returns EMPTY with zero data when the queue is empty.
- R9: `outstanding` increases by one for each accepted SUBMIT and decreases by one for each accepted completion push. When both are accepted in the same cycle, it is unchanged.
- R10: The master op FINISH (code 2) sets the end-of-submission mark and returns OK. An accepted SUBMIT clears the mark. `barrier_done` is 1 exactly when the mark is set and `outstanding` is 0.
- R11: When a SUBMIT and a poll reach an empty submission queue in the same cycle, the poll returns EMPTY and the entry stays queued for a later poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req_valid | input | 1 | Master request this cycle; it is always accepted |
| m_req_op | input | 2 | 0 SUBMIT, 1 DRAIN, 2 FINISH |
| m_req_data | input | 64 | Task entry for SUBMIT |
| m_rsp_valid | output | 1 | Master response strobe |
| m_rsp_code | output | 2 | 0 OK, 1 EMPTY, 2 RETRY |
| m_rsp_data | output | 64 | Drained completion record |
| w_req_valid | input | 4 | Per-worker request, held until granted |
| w_req_op | input | 4 | Per-worker op: 0 POLL, 1 COMPLETE |
| w_req_data | input | 256 | Per-worker 64-bit completion record, worker k at bits 64k+63:64k |
| w_grant | output | 4 | One-hot acceptance of a worker request this cycle |
| w_rsp_valid | output | 4 | Response strobe for the addressed worker |
| w_rsp_code | output | 8 | 2-bit response code per worker slot |
| w_rsp_data | output | 256 | Claimed task entry, in the slot of the addressed worker |
| outstanding | output | 11 | Tasks submitted but not yet reported complete |
| barrier_done | output | 1 | End mark set and no task outstanding |

## Verification
The bench builds the block with four workers, queue depths of 4, an outstanding cap of 6 and a response delay of 3 cycles. The small depths let random traffic reach both full queues and the outstanding cap many times, so refusals and the no-overwrite rule are exercised often. A delay of 3 separates the acceptance edge from the response edge, which makes an early or late response visible. Four simultaneous polls expose the round-robin order and show that each worker receives a distinct entry.

// File: rtl/tsq_pkg.sv
// Package: shared encodings for the task synchronization queue.
// Assumes: codes are 2 bits wide and match the documented port values.
package tsq_pkg;

    // Master request operations
    typedef enum logic [1:0] {
        MOP_SUBMIT = 2'd0,
        MOP_DRAIN  = 2'd1,
        MOP_FINISH = 2'd2
    } mop_e;

    // Worker request operations
    typedef enum logic {
        WOP_POLL     = 1'b0,
        WOP_COMPLETE = 1'b1
    } wop_e;

    // Response codes shared by both sides
    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_EMPTY = 2'd1,
        RSP_RETRY = 2'd2
    } rsp_e;

endpackage

// File: rtl/tsq_fifo.sv
// Module: tsq_fifo
// Synchronous first-in first-out store with a visible head entry.
// Assumes: the caller never pushes when full and never pops when empty;
// a push and a pop in the same cycle are both honoured.
module tsq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    fill;

    assign full_o  = (fill == CW'(DEPTH));
    assign empty_o = (fill == '0);
    assign head_o  = mem[rd_ptr];

    // Storage write: capture pushed entry at the write pointer
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= push_data_i;
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_i)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_i && !pop_i)      fill <= fill + 1'b1;
            else if (pop_i && !push_i) fill <= fill - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);  // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);  // R3

endmodule

// File: rtl/tsq_rr_arb.sv
// Module: tsq_rr_arb
// Round-robin arbiter: grants one requester per cycle, starting the search
// at the index after the last winner.
// Assumes: requests are held until granted; the grant is combinational.
module tsq_rr_arb #(
    parameter int N = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] gnt_idx_o,
    output logic          gnt_any_o
);
    logic [IW-1:0] start;

    // Winner search: first request at or after the start index
    always_comb begin
        gnt_o     = '0;
        gnt_idx_o = '0;
        gnt_any_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(start) + i;
            if (j >= N) j = j - N;
            if (!gnt_any_o && req_i[j]) begin
                gnt_any_o = 1'b1;
                gnt_idx_o = IW'(j);
                gnt_o[j]  = 1'b1;
            end
        end
    end

    // Start index moves past the latest winner
    always_ff @(posedge clk) begin
        if (!rst_n) start <= '0;
        else if (gnt_any_o)
            start <= (gnt_idx_o == IW'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));  // R6
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);  // R6

endmodule

// File: rtl/tsq_delay.sv
// Module: tsq_delay
// Fixed-latency response line: a record presented in one cycle appears at
// the output LAT cycles after the capturing edge.
// Assumes: LAT >= 1; one record may enter every cycle.
module tsq_delay #(
    parameter int LAT   = 2,
    parameter int WIDTH = 66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o
);
    logic [LAT-1:0]   vld;
    logic [WIDTH-1:0] dat [LAT];

    // Valid bits shift with reset
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else begin
            vld[0] <= valid_i;
            for (int k = 1; k < LAT; k++) vld[k] <= vld[k-1];
        end
    end

    // Payload shifts alongside, no reset needed
    always_ff @(posedge clk) begin
        dat[0] <= data_i;
        for (int k = 1; k < LAT; k++) dat[k] <= dat[k-1];
    end

    assign valid_o = vld[LAT-1];
    assign data_o  = dat[LAT-1];

endmodule

// File: rtl/task_sync_queue.sv
// Module: task_sync_queue
// Submission queue written by one master and polled by many workers, plus a
// completion queue written by workers and drained by the master; keeps an
// outstanding-task count and a barrier flag. Responses pass a delay line.
// Assumes: master requests are always accepted; worker requests are held
// until their w_grant bit is seen; all state updates at the accept edge.
module task_sync_queue
    import tsq_pkg::*;
#(
    parameter int NUM_WORKERS     = 4,
    parameter int ID_W            = 16,
    parameter int PTR_W           = 48,
    parameter int SUB_DEPTH       = 8,
    parameter int CMP_DEPTH       = 8,
    parameter int MAX_OUTSTANDING = 1024,
    parameter int RSP_LAT         = 2,
    localparam int DW    = ID_W + PTR_W,
    localparam int IW    = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1,
    localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      m_req_valid,
    input  logic [1:0]                m_req_op,
    input  logic [DW-1:0]             m_req_data,
    output logic                      m_rsp_valid,
    output logic [1:0]                m_rsp_code,
    output logic [DW-1:0]             m_rsp_data,
    input  logic [NUM_WORKERS-1:0]    w_req_valid,
    input  logic [NUM_WORKERS-1:0]    w_req_op,
    input  logic [NUM_WORKERS*DW-1:0] w_req_data,
    output logic [NUM_WORKERS-1:0]    w_grant,
    output logic [NUM_WORKERS-1:0]    w_rsp_valid,
    output logic [NUM_WORKERS*2-1:0]  w_rsp_code,
    output logic [NUM_WORKERS*DW-1:0] w_rsp_data,
    output logic [CNT_W-1:0]          outstanding,
    output logic                      barrier_done
);
    localparam int MRW = 2 + DW;
    localparam int WRW = IW + 2 + DW;

    logic          sub_push, sub_pop, sub_full, sub_empty;
    logic          cmp_push, cmp_pop, cmp_full, cmp_empty;
    logic [DW-1:0] sub_head, cmp_head;
    logic [IW-1:0] gidx;
    logic          gany;
    logic          sel_op;
    logic [DW-1:0] sel_data;
    logic          fin_mark;
    logic          cap_hit;
    rsp_e          m_code, w_code;
    logic [DW-1:0] m_data, w_data;
    logic [MRW-1:0] m_rec_out;
    logic [WRW-1:0] w_rec_out;
    logic           w_vld_out;

    tsq_fifo #(.DEPTH(SUB_DEPTH), .WIDTH(DW)) u_sub (
        .clk(clk), .rst_n(rst_n), .push_i(sub_push), .push_data_i(m_req_data),
        .pop_i(sub_pop), .head_o(sub_head), .full_o(sub_full), .empty_o(sub_empty));

    tsq_fifo #(.DEPTH(CMP_DEPTH), .WIDTH(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .push_i(cmp_push), .push_data_i(sel_data),
        .pop_i(cmp_pop), .head_o(cmp_head), .full_o(cmp_full), .empty_o(cmp_empty));

    tsq_rr_arb #(.N(NUM_WORKERS), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(w_req_valid), .gnt_o(w_grant),
        .gnt_idx_o(gidx), .gnt_any_o(gany));

    assign sel_op   = w_req_op[gidx];
    assign sel_data = w_req_data[gidx*DW +: DW];
    assign cap_hit  = (outstanding == CNT_W'(MAX_OUTSTANDING));

    // Queue enables: accept only what the queues can take
    assign sub_push = m_req_valid && (m_req_op == MOP_SUBMIT) && !sub_full && !cap_hit;
    assign cmp_pop  = m_req_valid && (m_req_op == MOP_DRAIN) && !cmp_empty;
    assign sub_pop  = gany && (sel_op == WOP_POLL) && !sub_empty;
    assign cmp_push = gany && (sel_op == WOP_COMPLETE) && !cmp_full;

    // Master response record
    always_comb begin
        m_data = '0;
        unique case (m_req_op)
            MOP_SUBMIT: m_code = sub_push ? RSP_OK : RSP_RETRY;
            MOP_DRAIN: begin
                m_code = cmp_empty ? RSP_EMPTY : RSP_OK;
                if (!cmp_empty) m_data = cmp_head;
            end
            MOP_FINISH: m_code = RSP_OK;
            default:    m_code = RSP_RETRY;
        endcase
    end

    // Worker response record for the granted worker
    always_comb begin
        w_data = '0;
        if (sel_op == WOP_POLL) begin
            w_code = sub_empty ? RSP_EMPTY : RSP_OK;
            if (!sub_empty) w_data = sub_head;
        end else begin
            w_code = cmp_full ? RSP_RETRY : RSP_OK;
        end
    end

    // Outstanding count and end-of-submission mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            fin_mark    <= 1'b0;
        end else begin
            if (sub_push && !cmp_push)      outstanding <= outstanding + 1'b1;
            else if (cmp_push && !sub_push) outstanding <= outstanding - 1'b1;
            if (sub_push) fin_mark <= 1'b0;
            else if (m_req_valid && m_req_op == MOP_FINISH) fin_mark <= 1'b1;
        end
    end

    assign barrier_done = fin_mark && (outstanding == '0);

    tsq_delay #(.LAT(RSP_LAT), .WIDTH(MRW)) u_mdly (
        .clk(clk), .rst_n(rst_n), .valid_i(m_req_valid), .data_i({m_code, m_data}),
        .valid_o(m_rsp_valid), .data_o(m_rec_out));

    tsq_delay #(.LAT(RSP_LAT), .WIDTH(WRW)) u_wdly (
        .clk(clk), .rst_n(rst_n), .valid_i(gany), .data_i({gidx, w_code, w_data}),
        .valid_o(w_vld_out), .data_o(w_rec_out));

    assign m_rsp_code = m_rec_out[DW +: 2];
    assign m_rsp_data = m_rec_out[DW-1:0];

    // Worker response fan-out: valid to the addressed worker only
    generate
        for (genvar g = 0; g < NUM_WORKERS; g++) begin : g_wrsp
            assign w_rsp_valid[g]           = w_vld_out && (w_rec_out[WRW-1 -: IW] == IW'(g));
            assign w_rsp_code[2*g +: 2]     = w_rec_out[DW +: 2];
            assign w_rsp_data[g*DW +: DW]   = w_rec_out[DW-1:0];
        end
    endgenerate

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (outstanding == $past(outstanding)) ||
                 (outstanding == $past(outstanding) + 1'b1) ||
                 ($past(outstanding) == outstanding + 1'b1));  // R9
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNT_W'(MAX_OUTSTANDING));  // R4
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(w_rsp_valid));  // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        barrier_done |-> (outstanding == '0));  // R10
    AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        m_rsp_valid |-> (m_rsp_code != 2'd3));  // R5

endmodule

// File: tb/tb_task_sync_queue.sv
module tb_task_sync_queue;
    localparam int NW  = 4;
    localparam int DW  = 64;
    localparam int SD  = 4;
    localparam int CD  = 4;
    localparam int MO  = 6;
    localparam int LAT = 3;
    localparam int CW  = $clog2(1024 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_req_valid = 1'b0;
    logic [1:0] m_req_op = '0;
    logic [DW-1:0] m_req_data = '0;
    logic m_rsp_valid;
    logic [1:0] m_rsp_code;
    logic [DW-1:0] m_rsp_data;
    logic [NW-1:0] w_req_valid = '0;
    logic [NW-1:0] w_req_op = '0;
    logic [NW*DW-1:0] w_req_data = '0;
    logic [NW-1:0] w_grant, w_rsp_valid;
    logic [NW*2-1:0] w_rsp_code;
    logic [NW*DW-1:0] w_rsp_data;
    logic [CW-1:0] outstanding;
    logic barrier_done;

    always #10 clk = ~clk;

    task_sync_queue #(.NUM_WORKERS(NW), .SUB_DEPTH(SD), .CMP_DEPTH(CD),
                      .MAX_OUTSTANDING(MO), .RSP_LAT(LAT)) dut (.*);

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] sq[$];
    logic [DW-1:0] cq[$];
    logic [DW-1:0] claimed[$];
    int out_cnt = 0;
    bit fin = 0;
    int rr_ptr = 0;
    bit rr_mon = 0;
    logic [DW-1:0] rr_got [NW];
    int rr_hits [NW];
    int id_seq = 1;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] new_entry();
        logic [DW-1:0] e;
        e = {16'(id_seq), 16'($urandom), 32'($urandom)};
        id_seq++;
        return e;
    endfunction

    task automatic chk_state();
        bit exp_done;
        exp_done = fin && (out_cnt == 0);
        chk(outstanding == CW'(out_cnt), "R9 outstanding", 64'(outstanding), 64'(out_cnt));
        chk(barrier_done == exp_done, "R10 barrier", 64'(barrier_done), 64'(exp_done));
    endtask

    // Master transaction with model prediction
    task automatic master_txn(input logic [1:0] op, input logic [DW-1:0] d);
        logic [1:0] ec;
        logic [DW-1:0] ed;
        ed = '0;
        if (op == 2'd0) begin
            if (sq.size() < SD && out_cnt < MO) begin
                ec = 2'd0; sq.push_back(d); out_cnt++; fin = 0;
            end else ec = 2'd2;
        end else if (op == 2'd1) begin
            if (cq.size() > 0) begin ec = 2'd0; ed = cq.pop_front(); end
            else ec = 2'd1;
        end else begin
            ec = 2'd0; fin = 1;
        end
        @(negedge clk);
        m_req_valid = 1'b1; m_req_op = op; m_req_data = d;
        @(negedge clk);
        m_req_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        chk(m_rsp_valid == 1'b0, "R5 master early", 64'(m_rsp_valid), 64'(0));
        @(negedge clk);
        chk(m_rsp_valid == 1'b1, "R5 master on time", 64'(m_rsp_valid), 64'(1));
        chk(m_rsp_code == ec, (op == 2'd0) ? "R4 submit code" : "R8 drain code", 64'(m_rsp_code), 64'(ec));
        chk(m_rsp_data == ed, "R8 drain data", m_rsp_data, ed);
        chk_state();
    endtask

    // Worker transaction with model prediction
    task automatic worker_txn(input int w, input bit op, input logic [DW-1:0] d);
        logic [1:0] ec;
        logic [DW-1:0] ed;
        ed = '0;
        if (op == 1'b0) begin
            if (sq.size() > 0) begin ec = 2'd0; ed = sq.pop_front(); claimed.push_back(ed); end
            else ec = 2'd1;
        end else begin
            if (cq.size() < CD) begin
                ec = 2'd0; cq.push_back(d); out_cnt--;
                foreach (claimed[i]) if (claimed[i] == d) begin claimed.delete(i); break; end
            end else ec = 2'd2;
        end
        @(negedge clk);
        w_req_valid[w] = 1'b1; w_req_op[w] = op; w_req_data[w*DW +: DW] = d;
        #1;
        chk(w_grant == NW'(1 << w), "R6 single grant", 64'(w_grant), 64'(1 << w));
        rr_ptr = (w + 1) % NW;
        @(negedge clk);
        w_req_valid[w] = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        chk(w_rsp_valid == '0, "R5 worker early", 64'(w_rsp_valid), 64'(0));
        @(negedge clk);
        chk(w_rsp_valid == NW'(1 << w), "R7 worker target", 64'(w_rsp_valid), 64'(1 << w));
        chk(w_rsp_code[2*w +: 2] == ec, (op == 1'b0) ? "R3 poll code" : "R4 complete code",
            64'(w_rsp_code[2*w +: 2]), 64'(ec));
        chk(w_rsp_data[w*DW +: DW] == ed, "R2 poll data", w_rsp_data[w*DW +: DW], ed);
        chk_state();
    endtask

    // Response monitor for the round-robin test
    always @(negedge clk) begin
        if (rr_mon) begin
            for (int k = 0; k < NW; k++) begin
                if (w_rsp_valid[k]) begin
                    rr_got[k] = w_rsp_data[k*DW +: DW];
                    rr_hits[k]++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(outstanding == '0, "R1 count", 64'(outstanding), 0);
        chk(barrier_done == 1'b0, "R1 done", 64'(barrier_done), 0);
        chk(m_rsp_valid == 1'b0 && w_rsp_valid == '0 && w_grant == '0, "R1 no response",
            64'({m_rsp_valid, w_rsp_valid, w_grant}), 0);

        // R3 empty poll, R8 empty drain
        worker_txn(2, 1'b0, '0);
        master_txn(2'd1, '0);

        // R2/R4 fill, refuse, drain in order
        for (int i = 0; i < SD; i++) master_txn(2'd0, new_entry());
        master_txn(2'd0, new_entry());               // R4 full refusal
        for (int i = 0; i < SD; i++) worker_txn(i, 1'b0, '0);  // R2 order, no overwrite

        // R4 outstanding cap: 4 claimed, add 2, next refused
        master_txn(2'd0, new_entry());
        master_txn(2'd0, new_entry());
        master_txn(2'd0, new_entry());               // cap 6 reached -> RETRY

        // R6/R7 round robin with all workers polling
        for (int i = 0; i < 2; i++) worker_txn(1, 1'b0, '0);
        for (int i = 0; i < SD; i++) begin
            if (out_cnt < MO) master_txn(2'd0, new_entry());
        end
        while (claimed.size() > 0 && cq.size() < CD) worker_txn(0, 1'b1, claimed[0]);
        while (cq.size() > 0) master_txn(2'd1, '0);
        while (sq.size() < NW && out_cnt < MO) master_txn(2'd0, new_entry());
        begin
            logic [DW-1:0] exp_e [NW];
            int order [NW];
            logic [NW-1:0] pend;
            int n;
            n = (sq.size() < NW) ? sq.size() : NW;
            for (int k = 0; k < NW; k++) begin rr_hits[k] = 0; rr_got[k] = '0; end
            rr_mon = 1;
            pend = '1;
            @(negedge clk);
            w_req_op = '0;
            w_req_valid = pend;
            for (int s = 0; s < NW; s++) begin
                int e;
                e = -1;
                for (int k = 0; k < NW; k++) begin
                    int j;
                    j = (rr_ptr + k) % NW;
                    if (e < 0 && pend[j]) e = j;
                end
                #1;
                chk(w_grant == NW'(1 << e), "R6 round robin order", 64'(w_grant), 64'(1 << e));
                order[s] = e;
                rr_ptr = (e + 1) % NW;
                pend[e] = 1'b0;
                @(negedge clk);
                w_req_valid = pend;
            end
            for (int s = 0; s < NW; s++) begin
                exp_e[order[s]] = (s < n) ? sq.pop_front() : '0;
                if (s < n) claimed.push_back(exp_e[order[s]]);
            end
            repeat (LAT + 1) @(negedge clk);
            rr_mon = 0;
            for (int k = 0; k < NW; k++) begin
                chk(rr_hits[k] == 1, "R7 one response each", 64'(rr_hits[k]), 1);
                chk(rr_got[k] == exp_e[k], "R7 distinct entry", rr_got[k], exp_e[k]);
            end
        end

        // Clear work, then R11 same-cycle submit and poll on empty queue
        while (claimed.size() > 0) begin
            if (cq.size() == CD) master_txn(2'd1, '0);
            worker_txn(3, 1'b1, claimed[0]);
        end
        while (cq.size() > 0) master_txn(2'd1, '0);
        while (sq.size() > 0) begin
            worker_txn(0, 1'b0, '0);
            worker_txn(0, 1'b1, claimed[0]);
            master_txn(2'd1, '0);
        end
        begin
            logic [DW-1:0] e;
            e = new_entry();
            @(negedge clk);
            m_req_valid = 1'b1; m_req_op = 2'd0; m_req_data = e;
            w_req_valid[1] = 1'b1; w_req_op[1] = 1'b0;
            @(negedge clk);
            m_req_valid = 1'b0; w_req_valid[1] = 1'b0;
            rr_ptr = 2;
            repeat (LAT - 1) @(negedge clk);
            chk(w_rsp_valid[1] && w_rsp_code[3:2] == 2'd1, "R11 poll sees empty",
                64'({w_rsp_valid[1], w_rsp_code[3:2]}), 64'({1'b1, 2'd1}));
            chk(m_rsp_valid && m_rsp_code == 2'd0, "R11 submit ok", 64'(m_rsp_code), 0);
            sq.push_back(e); out_cnt++; fin = 0;
            worker_txn(1, 1'b0, '0);                   // R11 entry still present
        end

        // R10 barrier: finish with work pending, then complete it
        master_txn(2'd2, '0);
        worker_txn(2, 1'b1, claimed[0]);              // count to 0, done rises
        master_txn(2'd1, '0);
        master_txn(2'd0, new_entry());                // submit clears mark

        // Constrained random traffic
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom % 20;
            if (r < 7) master_txn(2'd0, new_entry());
            else if (r < 12) worker_txn($urandom % NW, 1'b0, '0);
            else if (r < 16 && claimed.size() > 0) worker_txn($urandom % NW, 1'b1, claimed[0]);
            else if (r < 19) master_txn(2'd1, '0);
            else master_txn(2'd2, '0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule